// File: doc/BRIEF.md
# DDR2 Power-Up Initialization Sequencer

This block brings a DDR2 memory from power-up to a state where normal operation can begin. After reset it keeps the command bus quiet: every chip select and the RAS#, CAS# and WE# strobes stay high, clock enable stays low, and the data and strobe drivers stay off. This lasts for a stabilization interval set by the clock frequency and a wait time in microseconds. It then walks a fixed list of commands. The list starts with a no-operation that raises clock enable and a precharge of all banks. It ends with loads of extended mode registers 2, 3 and 1. Every command is followed by a programmable run of no-operation cycles.

The extended mode register 1 load enables the DLL, sets additive latency to zero and selects normal OCD operation. Output drive strength and termination come from parameters. Only after the gap that follows the last load does the block raise its done flag and its refresh-enable output. A memory controller keeps its periodic refresh engine off until then and takes over the bus once done is seen. All bus outputs leave through one register stage, so each value appears one clock after the internal state that selects it.

Top module: `ddr2_bringup_seq`

## Requirements
- R1: From reset, and through the first STAB_CYCLES = CLK_MHZ*STAB_US rising edges after reset is released, the bus shows deselect: all chip selects, RAS#, CAS# and WE# high, every CKE bit low, BA and address zero. The first command appears after rising edge STAB_CYCLES+1.
- R2: The command field {CS#, RAS#, CAS#, WE#} is encoded as deselect 1111, no-operation 0111, precharge 0010 and mode-register load 0000. The CS# value goes to every rank alike.
- R3: The first command is a no-operation. All CKE bits rise in that same cycle and never fall again before the next reset.
- R4: Commands are issued for one cycle each, in the order: no-operation, precharge-all, extended mode register 2 load, extended mode register 3 load, extended mode register 1 load.
- R5: Precharge-all drives address bit A10 high, all other address bits low, and BA = 0.
- R6: The extended mode register 2 load drives BA = 2 and the extended mode register 3 load drives BA = 3. Both drive every address bit to zero.
- R7: The extended mode register 1 load drives BA = 1 and A0 = 0 (DLL enabled). It also drives A5..A3 = 000 (additive latency zero) and A9..A7 = 000 (OCD normal). A1 takes DRV_REDUCED, A2 takes RTT_CODE[0] and A6 takes RTT_CODE[1]. All other bits are zero.
- R8: After precharge-all, exactly T_RP_CYC no-operation cycles follow; after every other command, exactly T_MRD_CYC. During these cycles CKE stays high and BA and the address are zero.
- R9: init_done and refresh_en stay low until the gap after the last load has elapsed. They both rise in the next cycle, and from then on they stay high while the bus carries only no-operation.
- R10: data_oe is low at all times, so the data and strobe pins stay undriven.
- R11: Reset asserted at any point returns the bus to the deselect state and restarts the whole sequence from R1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Memory-side clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mem_cs_n | output | RANKS | Chip selects, active low, one per rank |
| mem_ras_n | output | 1 | Row strobe, active low |
| mem_cas_n | output | 1 | Column strobe, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_cke | output | RANKS | Clock enable, one per rank |
| mem_ba | output | BANK_W | Bank address |
| mem_addr | output | ROW_W | Row address |
| data_oe | output | 1 | Drive enable for data and strobe pins |
| init_done | output | 1 | Sequence complete |
| refresh_en | output | 1 | Permission for periodic refresh |

## Verification
The bench compares every output of three instances against a cycle-exact trace computed arithmetically. The instances differ in stabilization length, gap lengths, rank count and mode fields. A short wait with one-cycle gaps separates the command-spacing logic from the stabilization counter. Unequal T_RP_CYC and T_MRD_CYC confirm that each gap is tied to the command it follows. Opposite drive and termination settings confirm that each field lands on its own address bit. The default configuration runs its full microsecond wait, and a reset applied in the middle of the mode loads shows that the sequence restarts from the quiet state.

// File: rtl/ddr2_init_pkg.sv
// Shared command encodings, phase type and step numbering for the
// DDR2 bring-up sequencer. Assumes a single-command-per-cycle bus.
package ddr2_init_pkg;

    // Command field order: {CS#, RAS#, CAS#, WE#}
    typedef logic [3:0] cmd_t;
    localparam cmd_t CMD_DESEL = 4'b1111;
    localparam cmd_t CMD_NOP   = 4'b0111;
    localparam cmd_t CMD_PRE   = 4'b0010;
    localparam cmd_t CMD_MRS   = 4'b0000;

    typedef enum logic [1:0] {
        PH_STAB,
        PH_ISSUE,
        PH_GAP,
        PH_DONE
    } phase_t;

    // Sequence order is behaviour: steps are issued in increasing value.
    typedef logic [2:0] step_t;
    localparam step_t STEP_NOP  = 3'd0;
    localparam step_t STEP_PREA = 3'd1;
    localparam step_t STEP_EMR2 = 3'd2;
    localparam step_t STEP_EMR3 = 3'd3;
    localparam step_t STEP_EMR1 = 3'd4;
    localparam step_t STEP_LAST = STEP_EMR1;

    // Address bit positions decoded by the memory device
    localparam int unsigned AB_ALLBANK = 10;
    localparam int unsigned AB_DRV     = 1;
    localparam int unsigned AB_RTT_LO  = 2;
    localparam int unsigned AB_RTT_HI  = 6;

endpackage

// File: rtl/ddr2_init_timer.sv
// Loadable down-counter used both for the stabilization wait and for
// the inter-command gaps. Resets to RST_VAL, counts down to zero and
// holds there; a load takes priority over counting.
module ddr2_init_timer #(
    parameter int unsigned CNT_W   = 16,
    parameter int unsigned RST_VAL = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);

    logic [CNT_W-1:0] cnt_q;

    // Count register: reset preset, reload, or decrement toward zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= CNT_W'(RST_VAL);
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    // Zero detect drives the sequencer's phase changes.
    assign expired = (cnt_q == '0);

endmodule

// File: rtl/ddr2_init_fsm.sv
// Phase and step control for the bring-up. Waits in PH_STAB until the
// timer expires. Each step then spends one cycle in PH_ISSUE and a
// timed run in PH_GAP. After the last step's gap it parks in PH_DONE.
// Assumes gap parameters of at least one cycle.
module ddr2_init_fsm
    import ddr2_init_pkg::*;
#(
    parameter int unsigned CNT_W     = 16,
    parameter int unsigned T_RP_CYC  = 3,
    parameter int unsigned T_MRD_CYC = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             expired,
    output phase_t           phase,
    output step_t            step,
    output logic             tmr_load,
    output logic [CNT_W-1:0] tmr_val
);

    localparam logic [CNT_W-1:0] RP_LOAD  = CNT_W'(T_RP_CYC - 1);
    localparam logic [CNT_W-1:0] MRD_LOAD = CNT_W'(T_MRD_CYC - 1);

    phase_t phase_q;
    step_t  step_q;

    // State register: advances phase and step on timer expiry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_STAB;
            step_q  <= STEP_NOP;
        end else begin
            case (phase_q)
                PH_STAB:  if (expired) phase_q <= PH_ISSUE;
                PH_ISSUE: phase_q <= PH_GAP;
                PH_GAP: begin
                    if (expired) begin
                        if (step_q == STEP_LAST) begin
                            phase_q <= PH_DONE;
                        end else begin
                            step_q  <= step_q + 3'd1;
                            phase_q <= PH_ISSUE;
                        end
                    end
                end
                default: phase_q <= PH_DONE;
            endcase
        end
    end

    // Gap length follows the command just issued.
    always_comb begin
        tmr_load = (phase_q == PH_ISSUE);
        tmr_val  = (step_q == STEP_PREA) ? RP_LOAD : MRD_LOAD;
    end

    assign phase = phase_q;
    assign step  = step_q;

    // R4
    issue_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_ISSUE) |=> (phase_q == PH_GAP && $stable(step_q)));

    // R4
    step_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_ISSUE && $past(phase_q) == PH_GAP)
            |-> (step_q == $past(step_q) + 3'd1));

    // R9
    done_park_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_DONE) |=> (phase_q == PH_DONE));

endmodule

// File: rtl/ddr2_init_decode.sv
// Combinational decode of phase and step into a bus command, bank
// address, row address, clock enable and completion. Mode fields not
// exposed as parameters are fixed: DLL on, additive latency zero, OCD
// normal. Assumes ROW_W >= 11 and BANK_W >= 2.
module ddr2_init_decode
    import ddr2_init_pkg::*;
#(
    parameter int unsigned ROW_W       = 14,
    parameter int unsigned BANK_W      = 3,
    parameter bit          DRV_REDUCED = 1'b0,
    parameter logic [1:0]  RTT_CODE    = 2'b00
) (
    input  phase_t            phase,
    input  step_t             step,
    output cmd_t              cmd,
    output logic [BANK_W-1:0] ba,
    output logic [ROW_W-1:0]  addr,
    output logic              cke,
    output logic              done
);

    // Command, address and enables for the current phase and step.
    always_comb begin
        cmd  = CMD_NOP;
        ba   = '0;
        addr = '0;
        cke  = 1'b1;
        done = 1'b0;
        case (phase)
            PH_STAB: begin
                cmd = CMD_DESEL;
                cke = 1'b0;
            end
            PH_ISSUE: begin
                case (step)
                    STEP_PREA: begin
                        cmd              = CMD_PRE;
                        addr[AB_ALLBANK] = 1'b1;
                    end
                    STEP_EMR2: begin
                        cmd = CMD_MRS;
                        ba  = BANK_W'(2);
                    end
                    STEP_EMR3: begin
                        cmd = CMD_MRS;
                        ba  = BANK_W'(3);
                    end
                    STEP_EMR1: begin
                        cmd             = CMD_MRS;
                        ba              = BANK_W'(1);
                        addr[AB_DRV]    = DRV_REDUCED;
                        addr[AB_RTT_LO] = RTT_CODE[0];
                        addr[AB_RTT_HI] = RTT_CODE[1];
                    end
                    default: cmd = CMD_NOP;
                endcase
            end
            PH_DONE: done = 1'b1;
            default: cmd = CMD_NOP;
        endcase
    end

endmodule

// File: rtl/ddr2_init_drive.sv
// Output register stage toward the pads. Registers the decoded command,
// address, clock enable and completion, and fans CS# and CKE out to
// every rank. The data and strobe drivers are never enabled.
module ddr2_init_drive
    import ddr2_init_pkg::*;
#(
    parameter int unsigned RANKS  = 2,
    parameter int unsigned ROW_W  = 14,
    parameter int unsigned BANK_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  cmd_t              cmd_i,
    input  logic [BANK_W-1:0] ba_i,
    input  logic [ROW_W-1:0]  addr_i,
    input  logic              cke_i,
    input  logic              done_i,
    output logic [RANKS-1:0]  cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [RANKS-1:0]  cke,
    output logic [BANK_W-1:0] ba,
    output logic [ROW_W-1:0]  addr,
    output logic              data_oe,
    output logic              done,
    output logic              refresh_en
);

    cmd_t              cmd_q;
    logic [BANK_W-1:0] ba_q;
    logic [ROW_W-1:0]  addr_q;
    logic [RANKS-1:0]  cke_q;
    logic              done_q;
    logic              ref_q;

    // Pad register: quiet bus with CKE low in reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q  <= CMD_DESEL;
            ba_q   <= '0;
            addr_q <= '0;
            cke_q  <= '0;
            done_q <= 1'b0;
            ref_q  <= 1'b0;
        end else begin
            cmd_q  <= cmd_i;
            ba_q   <= ba_i;
            addr_q <= addr_i;
            cke_q  <= {RANKS{cke_i}};
            done_q <= done_i;
            ref_q  <= done_i;
        end
    end

    // Broadcast the command strobes to all ranks.
    assign cs_n       = {RANKS{cmd_q[3]}};
    assign ras_n      = cmd_q[2];
    assign cas_n      = cmd_q[1];
    assign we_n       = cmd_q[0];
    assign cke        = cke_q;
    assign ba         = ba_q;
    assign addr       = addr_q;
    assign data_oe    = 1'b0;
    assign done       = done_q;
    assign refresh_en = ref_q;

    // R1
    quiet_while_cke_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cke_q == '0) |-> (cmd_q == CMD_DESEL && addr_q == '0 && ba_q == '0));

    // R3
    cke_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|cke_q) |=> (&cke_q));

    // R3
    cke_rise_nop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cke_q[0]) |-> (cmd_q == CMD_NOP));

    // R7
    emr1_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_q == CMD_MRS && ba_q == BANK_W'(1))
            |-> (addr_q[0] == 1'b0 && addr_q[5:3] == 3'b000 && addr_q[9:7] == 3'b000));

    // R9
    done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> (done_q && ref_q));

    // R9
    idle_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> (cmd_q == CMD_NOP && (&cke_q)));

endmodule

// File: rtl/ddr2_bringup_seq.sv
// Top of the DDR2 power-up initialization sequencer. Derives the
// stabilization count from CLK_MHZ and STAB_US, and ties together the
// timer, phase control, command decode and pad register stage.
// Assumes STAB_CYCLES, T_RP_CYC and T_MRD_CYC are all at least one.
module ddr2_bringup_seq #(
    parameter int unsigned CLK_MHZ     = 200,
    parameter int unsigned STAB_US     = 200,
    parameter int unsigned T_RP_CYC    = 3,
    parameter int unsigned T_MRD_CYC   = 2,
    parameter int unsigned RANKS       = 2,
    parameter int unsigned ROW_W       = 14,
    parameter int unsigned BANK_W      = 3,
    parameter bit          DRV_REDUCED = 1'b0,
    parameter logic [1:0]  RTT_CODE    = 2'b00
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [RANKS-1:0]  mem_cs_n,
    output logic              mem_ras_n,
    output logic              mem_cas_n,
    output logic              mem_we_n,
    output logic [RANKS-1:0]  mem_cke,
    output logic [BANK_W-1:0] mem_ba,
    output logic [ROW_W-1:0]  mem_addr,
    output logic              data_oe,
    output logic              init_done,
    output logic              refresh_en
);
    import ddr2_init_pkg::*;

    localparam int unsigned STAB_CYCLES = CLK_MHZ * STAB_US;
    localparam int unsigned GAP_MAX     = (T_RP_CYC > T_MRD_CYC) ? T_RP_CYC : T_MRD_CYC;
    localparam int unsigned CNT_MAX     = (STAB_CYCLES > GAP_MAX) ? STAB_CYCLES : GAP_MAX;
    localparam int unsigned CNT_W       = $clog2(CNT_MAX + 1);

    logic             expired;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    phase_t           phase;
    step_t            step;
    cmd_t             dec_cmd;
    logic [BANK_W-1:0] dec_ba;
    logic [ROW_W-1:0] dec_addr;
    logic             dec_cke;
    logic             dec_done;

    ddr2_init_timer #(
        .CNT_W   (CNT_W),
        .RST_VAL (STAB_CYCLES - 1)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (expired)
    );

    ddr2_init_fsm #(
        .CNT_W     (CNT_W),
        .T_RP_CYC  (T_RP_CYC),
        .T_MRD_CYC (T_MRD_CYC)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .expired  (expired),
        .phase    (phase),
        .step     (step),
        .tmr_load (tmr_load),
        .tmr_val  (tmr_val)
    );

    ddr2_init_decode #(
        .ROW_W       (ROW_W),
        .BANK_W      (BANK_W),
        .DRV_REDUCED (DRV_REDUCED),
        .RTT_CODE    (RTT_CODE)
    ) u_decode (
        .phase (phase),
        .step  (step),
        .cmd   (dec_cmd),
        .ba    (dec_ba),
        .addr  (dec_addr),
        .cke   (dec_cke),
        .done  (dec_done)
    );

    ddr2_init_drive #(
        .RANKS  (RANKS),
        .ROW_W  (ROW_W),
        .BANK_W (BANK_W)
    ) u_drive (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_i      (dec_cmd),
        .ba_i       (dec_ba),
        .addr_i     (dec_addr),
        .cke_i      (dec_cke),
        .done_i     (dec_done),
        .cs_n       (mem_cs_n),
        .ras_n      (mem_ras_n),
        .cas_n      (mem_cas_n),
        .we_n       (mem_we_n),
        .cke        (mem_cke),
        .ba         (mem_ba),
        .addr       (mem_addr),
        .data_oe    (data_oe),
        .done       (init_done),
        .refresh_en (refresh_en)
    );

endmodule

// File: tb/tb_ddr2_bringup_seq.sv
`timescale 1ns/1ps
// Bench: three sequencer configurations checked cycle by cycle against
// an arithmetically computed trace, including a restart by mid-run reset.
module tb_ddr2_bringup_seq;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;
    string ph = "";

    // Instance A: short wait, unequal gaps, reduced drive, RTT high bit
    logic [1:0]  a_cs, a_cke;
    logic        a_ras, a_cas, a_we, a_oe, a_done, a_ref;
    logic [2:0]  a_ba;
    logic [13:0] a_addr;
    ddr2_bringup_seq #(.CLK_MHZ(10), .STAB_US(3), .T_RP_CYC(3), .T_MRD_CYC(2),
        .RANKS(2), .DRV_REDUCED(1'b1), .RTT_CODE(2'b10)) dut (
        .clk(clk), .rst_n(rst_n), .mem_cs_n(a_cs), .mem_ras_n(a_ras),
        .mem_cas_n(a_cas), .mem_we_n(a_we), .mem_cke(a_cke), .mem_ba(a_ba),
        .mem_addr(a_addr), .data_oe(a_oe), .init_done(a_done), .refresh_en(a_ref));

    // Instance B: one rank, one-cycle gaps, RTT low bit
    logic        b_cs, b_cke;
    logic        b_ras, b_cas, b_we, b_oe, b_done, b_ref;
    logic [2:0]  b_ba;
    logic [13:0] b_addr;
    ddr2_bringup_seq #(.CLK_MHZ(3), .STAB_US(2), .T_RP_CYC(1), .T_MRD_CYC(1),
        .RANKS(1), .DRV_REDUCED(1'b0), .RTT_CODE(2'b01)) dut_b (
        .clk(clk), .rst_n(rst_n), .mem_cs_n(b_cs), .mem_ras_n(b_ras),
        .mem_cas_n(b_cas), .mem_we_n(b_we), .mem_cke(b_cke), .mem_ba(b_ba),
        .mem_addr(b_addr), .data_oe(b_oe), .init_done(b_done), .refresh_en(b_ref));

    // Instance C: default parameters (full 200 us at 200 MHz)
    logic [1:0]  c_cs, c_cke;
    logic        c_ras, c_cas, c_we, c_oe, c_done, c_ref;
    logic [2:0]  c_ba;
    logic [13:0] c_addr;
    ddr2_bringup_seq dut_c (
        .clk(clk), .rst_n(rst_n), .mem_cs_n(c_cs), .mem_ras_n(c_ras),
        .mem_cas_n(c_cas), .mem_we_n(c_we), .mem_cke(c_cke), .mem_ba(c_ba),
        .mem_addr(c_addr), .data_oe(c_oe), .init_done(c_done), .refresh_en(c_ref));

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s%s %s act=%0h exp=%0h", tag, ph, what, act, exp);
        end
    endtask

    // Expected bus state sampled after edge t (t=0: in reset).
    task automatic expect_at(input int s, input int trp, input int tmrd,
                             input bit drv, input bit [1:0] rtt, input int t,
                             output logic [3:0] cmd, output logic cke,
                             output logic [2:0] ba, output logic [13:0] addr,
                             output logic done, output string tag);
        int u;
        int len;
        bit found;
        cmd = 4'b1111; cke = 1'b0; ba = '0; addr = '0; done = 1'b0; tag = "R1";
        if (t > s) begin
            cmd = 4'b0111; cke = 1'b1; done = 1'b1; tag = "R9";
            u = t - s - 1;
            found = 1'b0;
            for (int k = 0; k < 5; k++) begin
                len = 1 + ((k == 1) ? trp : tmrd);
                if (!found && u < len) begin
                    found = 1'b1;
                    done = 1'b0;
                    if (u != 0) tag = "R8";
                    else begin
                        case (k)
                            0: tag = "R3";
                            1: begin tag = "R5"; cmd = 4'b0010; addr[10] = 1'b1; end
                            2: begin tag = "R6"; cmd = 4'b0000; ba = 3'd2; end
                            3: begin tag = "R6"; cmd = 4'b0000; ba = 3'd3; end
                            default: begin
                                tag = "R7"; cmd = 4'b0000; ba = 3'd1;
                                addr[1] = drv; addr[2] = rtt[0]; addr[6] = rtt[1];
                            end
                        endcase
                    end
                end else if (!found) begin
                    u = u - len;
                end
            end
        end
    endtask

    task automatic check_dut(input string nm, input int s, input int trp, input int tmrd,
                             input bit drv, input bit [1:0] rtt, input int t,
                             input logic [1:0] cs, input logic [1:0] ck,
                             input logic ras, input logic cas, input logic we,
                             input logic [2:0] ba, input logic [13:0] addr,
                             input logic done, input logic rf, input logic oe);
        logic [3:0] ec;
        logic ek, ed;
        logic [2:0] eb;
        logic [13:0] ea;
        string tg;
        expect_at(s, trp, tmrd, drv, rtt, t, ec, ek, eb, ea, ed, tg);
        // R2, R4: command field with CS# broadcast to ranks
        chk({cs, ras, cas, we} == {{2{ec[3]}}, ec[2:0]}, {tg, " R2 R4"},
            $sformatf("%s t=%0d cmd", nm, t), {cs, ras, cas, we}, {{2{ec[3]}}, ec[2:0]});
        chk(ck == {2{ek}}, (t > s) ? "R3" : "R1", $sformatf("%s t=%0d cke", nm, t),
            ck, {2{ek}});
        chk({ba, addr} == {eb, ea}, tg, $sformatf("%s t=%0d ba/addr", nm, t),
            {ba, addr}, {eb, ea});
        chk(done == ed && rf == ed, "R9", $sformatf("%s t=%0d done/refresh", nm, t),
            {done, rf}, {ed, ed});
        chk(oe == 1'b0, "R10", $sformatf("%s t=%0d data_oe", nm, t), oe, 0);
    endtask

    task automatic check_all(input int t);
        check_dut("A", 30, 3, 2, 1'b1, 2'b10, t, a_cs, a_cke, a_ras, a_cas, a_we,
                  a_ba, a_addr, a_done, a_ref, a_oe);
        check_dut("B", 6, 1, 1, 1'b0, 2'b01, t, {2{b_cs}}, {2{b_cke}}, b_ras, b_cas,
                  b_we, b_ba, b_addr, b_done, b_ref, b_oe);
        check_dut("C", 40000, 3, 2, 1'b0, 2'b00, t, c_cs, c_cke, c_ras, c_cas, c_we,
                  c_ba, c_addr, c_done, c_ref, c_oe);
    endtask

    task automatic run_cycles(input int n);
        for (int t = 1; t <= n; t++) begin
            @(posedge clk);
            @(negedge clk);
            check_all(t);
        end
    endtask

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        check_all(0);                 // R1 reset state
        rst_n = 1'b1;
        run_cycles(40);               // A is mid mode loads, B finished

        // R11: reset mid-sequence, then a complete rerun of all instances
        ph = " R11";
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_all(0);
        rst_n = 1'b1;
        run_cycles(40030);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL R9 watchdog act=running exp=finished");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

endmodule